// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block holds the digital half of a 10-bit successive-approximation converter. It divides the system clock into a converter tick, runs the sample and the bit-by-bit search against an external comparator, and drives the trial code to an external DAC. It also drives the channel select for an external analog mux. The mux, the comparator, the DAC and the reference sit outside the block.

Software uses four byte registers: control, channel, result low and result high. It enables the converter, starts a conversion or lets conversions run back to back, and takes each result together with the channel it came from. Completion sets a sticky flag. The flag can raise an interrupt request and is cleared by writing a one to it or by an acknowledge pulse. Once the result low byte has been read, the byte pair holds still until the high byte is read, so the two bytes always belong to one conversion.

Top module: `adc_sar_seq`

## Requirements
- R1: Control bits [2:0] select the tick divider. Codes 0 and 1 divide the system clock by 2. A code k from 2 to 7 divides it by 2^k.
- R2: The first conversion after enabling lasts 25 ticks and each later one lasts 13 ticks. When the enable and start bits are written together at edge E0, eoc_o first goes high after edge E0 + 26·div.
- R3: Writing 1 to control bit 6 (start) while control bit 7 (enable) is written 1 requests a conversion. Bit 6 reads 1 until that conversion completes and then returns to 0 when auto-trigger is off.
- R4: Completion sets control bit 4 (done). Writing a 1 to bit 4 clears it, and so does a high irq_ack_i. Writing a 0 to bit 4 leaves it unchanged.
- R5: irq_o is high exactly while the done flag and control bit 3 (interrupt enable) are both set.
- R6: With control bit 5 (auto-trigger) set, the next conversion begins on the tick that ends the previous one. After the first one, eoc_o pulses every 13·div cycles. The chain only begins after software sets the start bit.
- R7: A read of address 2 (result low) freezes the result and its tag. Later conversions do not change them until address 3 (result high) is read.
- R8: The channel register (address 1, bits [3:0]) is sampled one tick after a conversion starts. A later write to it affects only the next conversion.
- R9: Channel codes 0 to 11 select external inputs and code 12 selects the internal sensor. Codes 13 to 15 are reserved and keep mux_en_o low during the bit decisions.
- R10: Clearing the enable bit aborts a running conversion, so no completion follows and the start bit reads 0. The next conversion after re-enabling is long again.
- R11: Bits are resolved MSB first, one per tick. A trial bit is kept when cmp_i reports that the input is at or above dac_o, so an input level v from 0 to 1023 yields result v.
- R12: eoc_o is a one-cycle pulse for each completion. The high byte holds the channel tag in bits [7:4] and result bits [9:8] in bits [1:0]. The low byte holds result bits [7:0].
- R13: After reset every register reads 0, and irq_o, eoc_o, mux_en_o and dac_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (result reads have side effects) |
| reg_addr_i | input | 2 | Register address: 0 control, 1 channel, 2 result low, 3 result high |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears done |
| cmp_i | input | 1 | Comparator: input at or above dac_o |
| dac_o | output | 10 | Trial code to the DAC |
| mux_sel_o | output | 4 | Latched channel code to the analog mux |
| mux_en_o | output | 1 | Mux enable (busy and channel code not reserved) |
| eoc_o | output | 1 | One-cycle completion pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 10-bit result, a 25-tick long conversion and a 13-tick short conversion. Because the smallest divider gives a short conversion of under thirty cycles, every one of the 1024 input levels can be converted and compared with its code. The larger dividers are then swept across all eight codes, which checks the exact long and free-running periods up to divide-by-128. The bench models the comparator from a per-channel input table. This lets it see a mid-conversion channel change, a reserved code and the sensor code in the results and their tags.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W   = 10;
  localparam int CH_W    = 4;
  localparam int PS_W    = 3;
  localparam int SENS_CH = 12;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CHAN = 2'd1,
    A_RLO  = 2'd2,
    A_RHI  = 2'd3
  } reg_addr_e;

  function automatic logic chan_ok(input logic [CH_W-1:0] c);
    return c <= CH_W'(SENS_CH);
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  localparam int CNT_W = (1 << PS_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim;
  int unsigned sh;

  always_comb begin
    sh  = (sel_i == '0) ? 1 : int'(sel_i);
    lim = CNT_W'((1 << sh) - 1);
  end

  assign tick_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // smallest divide is 2, so ticks never touch
  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_W     = 10,
  parameter int CH_W      = 4,
  parameter int LONG_CYC  = 25,
  parameter int SHORT_CYC = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             go_i,
  input  logic             auto_i,
  input  logic [CH_W-1:0]  chsel_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic [CH_W-1:0]  ch_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] res_o
);
  localparam int CNT_W = $clog2(LONG_CYC + 1);
  localparam logic [CNT_W-1:0] LONG_L  = CNT_W'(LONG_CYC);
  localparam logic [CNT_W-1:0] SHORT_L = CNT_W'(SHORT_CYC);
  localparam logic [CNT_W-1:0] BITS_L  = CNT_W'(RES_W);
  localparam logic [RES_W-1:0] MSB     = {1'b1, {(RES_W-1){1'b0}}};

  logic             busy_q, first_q;
  logic [CNT_W-1:0] cnt_q, len;
  logic [RES_W-1:0] acc_q, ptr_q, acc_nx;
  logic [CH_W-1:0]  ch_q;

  assign len    = first_q ? LONG_L : SHORT_L;
  assign acc_nx = cmp_i ? (acc_q | ptr_q) : acc_q;
  assign done_o = tick_i && busy_q && (cnt_q == len);
  assign res_o  = acc_nx;
  assign dac_o  = acc_q | ptr_q;
  assign ch_o   = ch_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; first_q <= 1'b1; cnt_q <= '0;
      acc_q <= '0; ptr_q <= '0; ch_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0; first_q <= 1'b1; cnt_q <= '0;
      acc_q <= '0; ptr_q <= '0;
    end else if (tick_i) begin
      if (busy_q) begin
        if (cnt_q == len) begin
          first_q <= 1'b0;
          acc_q   <= '0;
          ptr_q   <= '0;
          busy_q  <= auto_i;
          cnt_q   <= auto_i ? CNT_W'(1) : '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(1)) ch_q <= chsel_i;
          // trial for the MSB goes out one tick before its decision
          if (cnt_q == len - BITS_L) ptr_q <= MSB;
          else if (ptr_q != '0) begin
            acc_q <= acc_nx;
            ptr_q <= ptr_q >> 1;
          end
        end
      end else if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
        acc_q  <= '0;
        ptr_q  <= '0;
      end
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q >= CNT_W'(1)) && (cnt_q <= len));

  p_ch_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q > CNT_W'(2)) |-> $stable(ch_q));

  p_dac_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (dac_o == '0));
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int RES_W = 10,
  parameter int CH_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [CH_W-1:0]  tag_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  output logic [RES_W-1:0] res_o,
  output logic [CH_W-1:0]  tag_o
);
  logic             frz_q;
  logic [RES_W-1:0] res_q;
  logic [CH_W-1:0]  tag_q;

  assign res_o = res_q;
  assign tag_o = tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q <= 1'b0; res_q <= '0; tag_q <= '0;
    end else begin
      if (rd_lo_i)      frz_q <= 1'b1;
      else if (rd_hi_i) frz_q <= 1'b0;
      // a completion on the same edge as the low read is dropped too
      if (upd_i && !frz_q && !rd_lo_i) begin
        res_q <= res_i;
        tag_q <= tag_i;
      end
    end
  end

  p_frozen_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frz_q) |-> ($stable(res_q) && $stable(tag_q)));
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int LONG_CYC  = 25,
  parameter int SHORT_CYC = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             irq_ack_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic [CH_W-1:0]  mux_sel_o,
  output logic             mux_en_o,
  output logic             eoc_o,
  output logic             irq_o
);
  logic            en_q, start_q, auto_q, done_q, ie_q, eoc_q;
  logic [PS_W-1:0] ps_q;
  logic [CH_W-1:0] chsel_q, tag;
  logic [RES_W-1:0] res_raw, res;
  logic tick, busy, fin, ctrl_wr;

  assign ctrl_wr = reg_we_i && (reg_addr_i == A_CTRL);

  adc_clk_div #(.PS_W(PS_W)) u_div (
    .clk_i, .rst_ni, .en_i(en_q), .sel_i(ps_q), .tick_o(tick)
  );

  adc_sar_core #(
    .RES_W(RES_W), .CH_W(CH_W), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)
  ) u_core (
    .clk_i, .rst_ni, .en_i(en_q), .tick_i(tick), .go_i(start_q),
    .auto_i(auto_q), .chsel_i(chsel_q), .cmp_i, .dac_o, .ch_o(mux_sel_o),
    .busy_o(busy), .done_o(fin), .res_o(res_raw)
  );

  adc_result_reg #(.RES_W(RES_W), .CH_W(CH_W)) u_res (
    .clk_i, .rst_ni, .upd_i(fin), .res_i(res_raw), .tag_i(mux_sel_o),
    .rd_lo_i(reg_re_i && reg_addr_i == A_RLO),
    .rd_hi_i(reg_re_i && reg_addr_i == A_RHI),
    .res_o(res), .tag_o(tag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; start_q <= 1'b0; auto_q <= 1'b0; done_q <= 1'b0;
      ie_q <= 1'b0; ps_q <= '0; chsel_q <= '0; eoc_q <= 1'b0;
    end else begin
      eoc_q <= fin;
      if (ctrl_wr) begin
        en_q   <= reg_wdata_i[7];
        auto_q <= reg_wdata_i[5];
        ie_q   <= reg_wdata_i[3];
        ps_q   <= reg_wdata_i[2:0];
      end
      if (reg_we_i && reg_addr_i == A_CHAN) chsel_q <= reg_wdata_i[CH_W-1:0];

      if (ctrl_wr && !reg_wdata_i[7])      start_q <= 1'b0;
      else if (ctrl_wr && reg_wdata_i[6])  start_q <= 1'b1;
      else if (!en_q)                      start_q <= 1'b0;
      else if (fin && !auto_q)             start_q <= 1'b0;

      if (fin)                                      done_q <= 1'b1;
      else if ((ctrl_wr && reg_wdata_i[4]) || irq_ack_i) done_q <= 1'b0;
    end
  end

  assign eoc_o    = eoc_q;
  assign irq_o    = done_q && ie_q;
  assign mux_en_o = busy && chan_ok(mux_sel_o);

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      A_CTRL: reg_rdata_o = {en_q, start_q, auto_q, done_q, ie_q, ps_q};
      A_CHAN: reg_rdata_o = {{(8-CH_W){1'b0}}, chsel_q};
      A_RLO:  reg_rdata_o = res[7:0];
      A_RHI:  reg_rdata_o = {tag, {(4-(RES_W-8)){1'b0}}, res[RES_W-1:8]};
      default: reg_rdata_o = '0;
    endcase
  end

  p_eoc_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> done_q);

  p_start_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_q) |-> (!en_q || $past(fin && !auto_q)));
endmodule

// File: tb/adc_sar_seq_test.sv
module adc_sar_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0, ack = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wd = '0, rdata;
  logic cmp, mux_en, eoc, irq;
  logic [9:0] dac;
  logic [3:0] msel;
  logic [9:0] vin [16];
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  assign cmp = mux_en && (vin[msel] >= dac);

  adc_sar_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .irq_ack_i(ack), .cmp_i(cmp), .dac_o(dac), .mux_sel_o(msel),
    .mux_en_o(mux_en), .eoc_o(eoc), .irq_o(irq)
  );

  function automatic logic [7:0] ctl(bit en, bit st, bit au, bit dn, bit ie, int ps);
    return {en, st, au, dn, ie, 3'(ps)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wd = d;
    @(posedge clk);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(posedge clk);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_eoc(output int n, input int lim);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!eoc && n < lim);
  endtask

  task automatic get_res(output int v, output int t);
    logic [7:0] lo, hi;
    rd(2'd2, lo); rd(2'd3, hi);
    v = {hi[1:0], lo}; t = hi[7:4];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, v, t, div, cnt;
    for (int i = 0; i < 16; i++) vin[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk(d == 0, "R13 reg", d, 0);
    end
    chk(!irq && !eoc && !mux_en && dac == 0, "R13 outputs", {irq, eoc, mux_en, |dac}, 0);

    // R1 R2 R6 all divider codes, auto-trigger chain
    for (int ps = 0; ps < 8; ps++) begin
      div = (ps == 0) ? 2 : (1 << ps);
      wr(2'd0, ctl(1, 1, 1, 1, 0, ps));
      wait_eoc(n, 30 * div);
      chk(n == 26 * div, "R2 R1 first conversion", n, 26 * div);
      wait_eoc(n, 30 * div);
      chk(n == 13 * div, "R6 R1 free-run period", n, 13 * div);
      wr(2'd0, 8'h00);
    end

    // R3 start bit life, R11 sweep at divide 2
    vin[0] = 10'd5;
    wr(2'd1, 8'd0);
    wr(2'd0, ctl(1, 1, 0, 1, 0, 0));
    rd(2'd0, d); chk(d[6] == 1'b1, "R3 start reads 1 while busy", d[6], 1);
    wait_eoc(n, 200);
    rd(2'd0, d); chk(d[6] == 1'b0, "R3 start cleared at completion", d[6], 0);
    for (int lv = 0; lv < 1024; lv++) begin
      vin[0] = 10'(lv);
      wr(2'd0, ctl(1, 1, 0, 1, 0, 0));
      wait_eoc(n, 200);
      if (lv == 7) chk(n >= 27 && n <= 28, "R2 short conversion", n, 28);
      get_res(v, t);
      chk(v == lv, "R11 result", v, lv);
    end

    // R12 one-cycle eoc, R4 R5 done and irq
    wr(2'd0, ctl(1, 1, 0, 1, 0, 0));
    wait_eoc(n, 200);
    @(negedge clk); chk(!eoc, "R12 eoc one cycle", eoc, 0);
    rd(2'd0, d); chk(d[4] == 1'b1, "R4 done set", d[4], 1);
    chk(!irq, "R5 irq off while disabled", irq, 0);
    wr(2'd0, ctl(1, 0, 0, 0, 1, 0));
    rd(2'd0, d); chk(d[4] == 1'b1, "R4 writing 0 keeps done", d[4], 1);
    chk(irq, "R5 irq on", irq, 1);
    wr(2'd0, ctl(1, 0, 0, 1, 1, 0));
    rd(2'd0, d); chk(d[4] == 1'b0, "R4 w1c", d[4], 0);
    chk(!irq, "R5 irq off after clear", irq, 0);
    wr(2'd0, ctl(1, 1, 0, 0, 1, 0));
    wait_eoc(n, 200);
    @(negedge clk); chk(irq, "R5 irq on completion", irq, 1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    rd(2'd0, d); chk(d[4] == 1'b0, "R4 ack clears", d[4], 0);
    chk(!irq, "R5 irq off after ack", irq, 0);

    // R8 channel latch
    vin[2] = 10'd300; vin[5] = 10'd700;
    wr(2'd1, 8'd2);
    wr(2'd0, ctl(1, 1, 0, 1, 0, 0));
    repeat (10) @(negedge clk);
    chk(mux_en, "R9 mux enabled for valid channel", mux_en, 1);
    wr(2'd1, 8'd5);
    wait_eoc(n, 200);
    get_res(v, t);
    chk(v == 300, "R8 value of latched channel", v, 300);
    chk(t == 2, "R8 R12 tag", t, 2);
    wr(2'd0, ctl(1, 1, 0, 1, 0, 0));
    wait_eoc(n, 200);
    get_res(v, t);
    chk(v == 700 && t == 5, "R8 new channel next conversion", v, 700);

    // R9 sensor and reserved codes
    vin[12] = 10'd512;
    wr(2'd1, 8'd12);
    wr(2'd0, ctl(1, 1, 0, 1, 0, 0));
    wait_eoc(n, 200);
    get_res(v, t);
    chk(v == 512 && t == 12, "R9 sensor", v, 512);
    vin[14] = 10'd999;
    wr(2'd1, 8'd14);
    wr(2'd0, ctl(1, 1, 0, 1, 0, 0));
    repeat (12) @(negedge clk);
    chk(!mux_en, "R9 reserved mux_en low", mux_en, 0);
    wait_eoc(n, 200);
    get_res(v, t);
    chk(v == 0, "R9 reserved result", v, 0);
    chk(t == 14, "R9 reserved tag", t, 14);

    // R7 freeze across free-running completions
    vin[0] = 10'h155;
    wr(2'd1, 8'd0);
    wr(2'd0, ctl(1, 1, 1, 1, 0, 0));
    wait_eoc(n, 200); wait_eoc(n, 200);
    rd(2'd2, d); chk(d == 8'h55, "R7 low byte", d, 8'h55);
    vin[0] = 10'h2AA;
    wait_eoc(n, 200); wait_eoc(n, 200);
    rd(2'd3, d); chk(d == 8'h01, "R7 high byte held", d, 8'h01);
    wait_eoc(n, 200);
    get_res(v, t);
    chk(v == 10'h2AA, "R7 released after high read", v, 10'h2AA);

    // R10 abort and long conversion again
    wr(2'd0, ctl(1, 1, 0, 1, 0, 0));
    repeat (8) @(negedge clk);
    wr(2'd0, 8'h00);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); if (eoc) cnt++;
    end
    chk(cnt == 0, "R10 no completion after abort", cnt, 0);
    rd(2'd0, d); chk(d[6] == 1'b0, "R10 start cleared", d[6], 0);
    wr(2'd0, ctl(1, 1, 0, 1, 0, 0));
    wait_eoc(n, 200);
    chk(n == 52, "R10 long after re-enable", n, 52);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule